// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command bus from reset until the memory can accept normal traffic. While the clock is not yet reported stable it drives COMMAND INHIBIT. Once the clock is stable it holds NOP for a programmable settle interval, counted in clock cycles. It then issues a precharge of all banks, a fixed number of auto-refresh commands and a mode-register load. Every two commands are separated by a programmable cycle gap.

All command, address and bank outputs come straight from flip-flops, so the memory samples stable values on each rising clock edge. The mode-register value is taken from an input word. After the last gap has expired, a ready flag rises and stays high until the next reset. From then on the block drives only NOP.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted, and at once when it is asserted mid-sequence, the outputs are COMMAND INHIBIT ({cs_n,ras_n,cas_n,we_n} = 4'b1111), addr = 0, ba = 0 and init_done = 0.
- R2: While clk_stable has not yet been seen high, the block drives COMMAND INHIBIT continuously and issues no other command.
- R3: Once clk_stable is high, the block drives NOP (4'b0111) for exactly WAIT_CYC cycles before the first real command. If clk_stable drops during this interval, the output returns to COMMAND INHIBIT and the full interval restarts when clk_stable comes back.
- R4: The first command is PRECHARGE (4'b0010). It carries addr bit 10 high and every other addr bit low, which selects all banks.
- R5: Exactly N_REF AUTO REFRESH commands (4'b0001) follow. The first comes T_RP cycles after the precharge, and each later one comes T_RFC cycles after the previous refresh.
- R6: LOAD MODE REGISTER (4'b0000) is issued T_RFC cycles after the last refresh, with addr equal to mode_word and ba = 0.
- R7: init_done rises exactly T_MRD cycles after the mode load and then stays high. While init_done is high the command is NOP.
- R8: Between the commands only NOP is driven. After the precharge, clk_stable is ignored: dropping it changes neither the command sequence nor its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_stable | input | 1 | High when the clock is within its specification |
| mode_word | input | ADDR_W | Value placed on addr during the mode-register load |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (bit 10 = all-banks flag on precharge) |
| ba | output | BA_W | Bank address |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
The bench logs every non-NOP command with its cycle stamp and measures each gap against the parameters. A design off by one on any counter therefore shows a gap one cycle long or short. It drops clk_stable part-way through the settle interval. A design that resumed the count instead of restarting it would precharge too early. It also drops clk_stable after the precharge, where a design that still listened would fall back to COMMAND INHIBIT. Further checks cover a mode word with bit 10 set, which would expose a swapped address source, and a reset asserted mid-refresh, which must clear the outputs at once rather than on a later edge.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command pin encoding {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'b1111,
    CMD_NOP     = 4'b0111,
    CMD_PRE     = 4'b0010,
    CMD_REF     = 4'b0001,
    CMD_LMR     = 4'b0000
  } cmd_t;

  typedef enum logic [3:0] {
    ST_INHIBIT,
    ST_WAIT,
    ST_PRE,
    ST_TRP,
    ST_REF,
    ST_TRFC,
    ST_LMR,
    ST_TMRD,
    ST_DONE
  } state_t;

  // Address bit that selects all banks during precharge
  localparam int AP_BIT = 10;

endpackage

// File: rtl/sdram_init_rst_sync.sv
module sdram_init_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  state_t            st,
  input  logic [ADDR_W-1:0] mode_word,
  output cmd_t              cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              done
);

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    done = 1'b0;
    unique case (st)
      ST_INHIBIT: cmd = CMD_INHIBIT;
      ST_PRE: begin
        cmd          = CMD_PRE;
        addr[AP_BIT] = 1'b1;
      end
      ST_REF:  cmd = CMD_REF;
      ST_LMR: begin
        cmd  = CMD_LMR;
        addr = mode_word;
      end
      ST_DONE: done = 1'b1;
      default: cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2,
  parameter int WAIT_CYC = 13300,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 10,
  parameter int T_MRD    = 2,
  parameter int N_REF    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_stable,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done
);

  localparam int GAP_MAX = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                          : ((T_RP  > T_MRD) ? T_RP  : T_MRD);
  localparam int CNT_MAX = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int RC_W    = $clog2(N_REF + 1);

  logic             rst_n_int;
  state_t           state_q, state_d;
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic [RC_W-1:0]  ref_cnt_q;
  logic             ref_inc;

  cmd_t              cmd_d, cmd_q;
  logic [ADDR_W-1:0] addr_d;
  logic [BA_W-1:0]   ba_d;
  logic              done_d;

  sdram_init_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    tmr_val  = '0;
    ref_inc  = 1'b0;
    unique case (state_q)
      ST_INHIBIT: begin
        if (clk_stable) begin
          state_d  = ST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WAIT_CYC - 1);
        end
      end
      ST_WAIT: begin
        if (!clk_stable)   state_d = ST_INHIBIT;
        else if (tmr_zero) state_d = ST_PRE;
        else               tmr_dec = 1'b1;
      end
      ST_PRE: begin
        state_d  = ST_TRP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RP - 2);
      end
      ST_TRP: begin
        if (tmr_zero) state_d = ST_REF;
        else          tmr_dec = 1'b1;
      end
      ST_REF: begin
        state_d  = ST_TRFC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RFC - 2);
        ref_inc  = 1'b1;
      end
      ST_TRFC: begin
        if (tmr_zero) state_d = (ref_cnt_q == RC_W'(N_REF)) ? ST_LMR : ST_REF;
        else          tmr_dec = 1'b1;
      end
      ST_LMR: begin
        state_d  = ST_TMRD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_MRD - 2);
      end
      ST_TMRD: begin
        if (tmr_zero) state_d = ST_DONE;
        else          tmr_dec = 1'b1;
      end
      default: state_d = ST_DONE;
    endcase
  end

  sdram_init_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .st        (state_d),
    .mode_word (mode_word),
    .cmd       (cmd_d),
    .addr      (addr_d),
    .ba        (ba_d),
    .done      (done_d)
  );

  // State and output registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q   <= ST_INHIBIT;
      ref_cnt_q <= '0;
      cmd_q     <= CMD_INHIBIT;
      addr      <= '0;
      ba        <= '0;
      init_done <= 1'b0;
    end else begin
      state_q   <= state_d;
      cmd_q     <= cmd_d;
      addr      <= addr_d;
      ba        <= ba_d;
      init_done <= done_d;
      if (ref_inc) begin
        ref_cnt_q <= ref_cnt_q + RC_W'(1);
      end
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int N_REF  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mode_word,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              init_done
);

  logic [3:0] pins;
  logic [7:0] ref_seen;
  logic       lmr_seen;

  assign pins = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_seen <= '0;
      lmr_seen <= 1'b0;
    end else begin
      if (pins == 4'b0001 && ref_seen != 8'hFF) ref_seen <= ref_seen + 8'd1;
      if (pins == 4'b0000) lmr_seen <= 1'b1;
    end
  end

  p_pre_all_banks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0010) |-> addr[10]);

  p_lmr_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0000) |-> (addr == $past(mode_word) && ba == '0));

  p_lmr_after_refs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0000) |-> (ref_seen == 8'(N_REF)));

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (pins == 4'b0111));

  p_done_after_lmr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> lmr_seen);

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
  .ADDR_W (ADDR_W),
  .BA_W   (BA_W),
  .N_REF  (N_REF)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_word (mode_word),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .addr      (addr),
  .ba        (ba),
  .init_done (init_done)
);

// File: tb/sdram_powerup_seq_bench.sv
`timescale 1ns/1ps
module sdram_powerup_seq_bench;

  localparam int ADDR_W = 12;
  localparam int BA_W   = 2;
  localparam int WAITC  = 40;
  localparam int TRP    = 3;
  localparam int TRFC   = 7;
  localparam int TMRD   = 2;
  localparam int NREF   = 2;
  localparam int RUN    = 200;

  // {mode[31:20], stable_delay[19:12], drop_offset[11:4], late_drop[3:0]}
  localparam logic [31:0] VECS [0:3] = '{
    {12'h033, 8'd5,  8'd0,  4'd0},
    {12'h022, 8'd12, 8'd10, 4'd0},
    {12'h5A7, 8'd4,  8'd0,  4'd1},
    {12'h237, 8'd20, 8'd35, 4'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              clk_stable = 1'b0;
  logic [ADDR_W-1:0] mode_word = '0;
  logic              cs_n, ras_n, cas_n, we_n, init_done;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0]   ba;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  sdram_powerup_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .WAIT_CYC(WAITC),
    .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .N_REF(NREF)
  ) u_sdram_powerup_seq (
    .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .mode_word(mode_word),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_check(input string tag);
    check(cs_n && ras_n && cas_n && we_n, tag, {cs_n, ras_n, cas_n, we_n}, 15);
    check(addr == '0 && ba == '0 && !init_done, tag, int'(addr) + int'(init_done), 0);
  endtask

  task automatic run_vec(input logic [31:0] v, input bit abort);
    int ev_cmd [8];
    int ev_cyc [8];
    int ev_addr[8];
    int ev_ba  [8];
    int n_ev = 0, restarts = 0, first_nop = -1, first_any = -1;
    int done_cyc = -1, done_drop = 0, inh_after_pre = 0;
    bit prev_inh = 1'b1;
    int delay = int'(v[19:12]);
    int drop  = int'(v[11:4]);
    bit late  = v[0];
    mode_word  = v[31:20];
    clk_stable = 1'b0;
    rst_n      = 1'b1;
    #1 rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    reset_check("R1 reset state");
    rst_n = 1'b1;
    for (int k = 0; k < RUN; k++) begin
      @(negedge clk);
      if (cs_n) begin
        if (n_ev > 0) inh_after_pre++;
        prev_inh = 1'b1;
      end else if ({ras_n, cas_n, we_n} == 3'b111) begin
        if (prev_inh) begin
          restarts++;
          first_nop = k;
          if (first_any < 0) first_any = k;
        end
        prev_inh = 1'b0;
      end else begin
        if (n_ev < 8) begin
          ev_cmd[n_ev]  = {cs_n, ras_n, cas_n, we_n};
          ev_cyc[n_ev]  = k;
          ev_addr[n_ev] = int'(addr);
          ev_ba[n_ev]   = int'(ba);
        end
        n_ev++;
        prev_inh = 1'b0;
      end
      if (init_done && done_cyc < 0) done_cyc = k;
      if (done_cyc >= 0 && !init_done) done_drop++;
      if (abort && n_ev == 2) begin
        #1 rst_n = 1'b0;
        #1 reset_check("R1 mid-sequence reset");
        return;
      end
      if (late && n_ev >= 2) clk_stable = 1'b0;
      else clk_stable = (k >= delay) && !(drop != 0 && k >= delay + drop && k < delay + drop + 3);
    end
    check(first_any > delay, "R2 inhibit until clock stable", first_any, delay + 1);
    check(restarts == (drop != 0 ? 2 : 1), "R3 wait restarts", restarts, drop != 0 ? 2 : 1);
    check(n_ev == 4, "R8 command count", n_ev, 4);
    if (n_ev >= 4) begin
      check(ev_cyc[0] - first_nop == WAITC, "R3 settle length", ev_cyc[0] - first_nop, WAITC);
      check(ev_cmd[0] == 2 && ev_addr[0] == (1 << 10), "R4 precharge all", ev_addr[0], 1 << 10);
      check(ev_cmd[1] == 1 && ev_cmd[2] == 1, "R5 refresh codes", ev_cmd[1] * 16 + ev_cmd[2], 17);
      check(ev_cyc[1] - ev_cyc[0] == TRP, "R5 tRP gap", ev_cyc[1] - ev_cyc[0], TRP);
      check(ev_cyc[2] - ev_cyc[1] == TRFC, "R5 tRFC gap", ev_cyc[2] - ev_cyc[1], TRFC);
      check(ev_cmd[3] == 0 && ev_cyc[3] - ev_cyc[2] == TRFC, "R6 mode load timing",
            ev_cyc[3] - ev_cyc[2], TRFC);
      check(ev_addr[3] == int'(v[31:20]) && ev_ba[3] == 0, "R6 mode word",
            ev_addr[3], int'(v[31:20]));
      check(done_cyc - ev_cyc[3] == TMRD, "R7 done delay", done_cyc - ev_cyc[3], TMRD);
    end
    check(done_drop == 0, "R7 done sticky", done_drop, 0);
    check(inh_after_pre == 0, "R8 clk_stable ignored after precharge", inh_after_pre, 0);
    #1 rst_n = 1'b0;
    #1 reset_check("R1 reset after done");
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) run_vec(VECS[i], 1'b0);
    // Directed: reset asserted during the refresh phase
    run_vec({12'h0F0, 8'd6, 8'd0, 4'd0}, 1'b1);
    // Directed: full run after an aborted one, mode word with all bits set
    run_vec({12'hFFF, 8'd7, 8'd0, 4'd0}, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule